// File: doc/BRIEF.md
# Windowed Line-Peak Brownout Monitor

This block watches the rectified line through a stream of digitized bulk-capacitor samples while the converter is switching. Bulk ripple grows with load, so a single sample says little about the line. The block therefore splits time into back-to-back windows of fixed length. The default window is sized at 11 ms, which holds at least one full half-cycle for line frequencies down to 47 Hz. At the end of each window the block reports the highest sample it saw, and that value is taken as the AC peak. Each reported peak is compared with a programmable turn-off level. A run of low peaks trips a brownout only after a programmable persistence delay has fully elapsed. The trip halts PWM and asks the start-up sequencer for its low-power reset path, which is followed by VDD discharge and a restart.

A four-state controller decides what happens. IDLE is entered after reset or whenever `run_en` is low; it leaves for WATCH when `run_en` is high (transition *arm*). In WATCH, a reported peak below the level moves it to LOW_WAIT (transition *sag*). In LOW_WAIT, a reported peak at or above the level sends it back to WATCH (transition *recover*), and this takes priority. Otherwise, once the delay has elapsed, it moves to TRIPPED (transition *trip*). TRIPPED holds until `run_en` drops. From every state, a low `run_en` leads to IDLE (transition *disarm*).

Top module: `line_peak_guard`

## Requirements
- R1: After reset, `peak_valid`, `brownout_evt` and `lp_req` are 0 and `pwm_halt` is 1.
- R2: While `run_en` is high, `peak_valid` pulses high for exactly one cycle once every WINDOW_CYC cycles. The first pulse follows the WINDOW_CYC-th rising edge at which `run_en` is sampled high.
- R3: `peak_value` equals the largest `smp_data` accepted with `smp_valid` during the window. This includes samples on the window's first and last edges. A window with no valid sample reports 0.
- R4: The maximum restarts with every window, so a window with lower samples reports its own, lower peak.
- R5: A peak equal to `acoff_lvl` counts as healthy and never starts or continues the brownout delay.
- R6: If the first low peak pulse is seen after edge e, and no healthy peak follows, `brownout_evt` rises after edge e+DELAY_CYC+1. This holds even when the delay spans several windows.
- R7: A healthy peak clears the delay, so a later low peak needs the full DELAY_CYC again.
- R8: `brownout_evt` is a single-cycle pulse. After it, `lp_req` and `pwm_halt` stay high and no further pulse occurs until `run_en` drops.
- R9: With `run_en` low, the controller is in IDLE one cycle later: `lp_req` is 0 and `pwm_halt` is 1. No `peak_valid` pulse occurs while `run_en` is low. On re-enable, windowing restarts from the beginning.
- R10: `pwm_halt` is 0 while the controller is in WATCH or LOW_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Monitoring enable; low holds all counters cleared |
| smp_valid | input | 1 | Strobe marking a new bulk sample |
| smp_data | input | SAMPLE_W | Bulk-capacitor sample |
| acoff_lvl | input | SAMPLE_W | Turn-off level for the window peak |
| peak_valid | output | 1 | One-cycle strobe at each window end |
| peak_value | output | SAMPLE_W | Peak of the last completed window |
| brownout_evt | output | 1 | One-cycle brownout event |
| pwm_halt | output | 1 | PWM must not switch |
| lp_req | output | 1 | Request for the low-power reset path |

## Verification
A corrupted window counter shows up at the ports within one window, as a `peak_valid` pulse that comes early, late or twice. A maximum register that is not cleared shows up in the next window's `peak_value`, so the bench follows a high window with a lower one. A delay counter that is not cleared, or that misses a count, moves `brownout_evt` by at least one cycle relative to the low peak that started the delay. The bench therefore measures the exact edge of the event, and it does so after both a persistent sag and a sag that was interrupted by recovery.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WATCH    = 2'd1,
        ST_LOW_WAIT = 2'd2,
        ST_TRIPPED  = 2'd3
    } lpg_state_e;
endpackage

// File: rtl/lpg_window_peak.sv
module lpg_window_peak #(
    parameter int SAMPLE_W   = 10,
    parameter int WINDOW_CYC = 2_200_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                peak_valid,
    output logic [SAMPLE_W-1:0] peak_value
);
    localparam int WCW = $clog2(WINDOW_CYC);
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WINDOW_CYC - 1);

    logic [WCW-1:0]      win_cnt_q;
    logic [SAMPLE_W-1:0] max_q;
    logic                have_q;
    logic                win_end;
    logic [SAMPLE_W-1:0] merged;

    assign win_end = run_en && (win_cnt_q == WIN_LAST);

    // first valid sample of a window reloads, later ones compare
    always_comb begin
        if (have_q) begin
            merged = (smp_valid && (smp_data > max_q)) ? smp_data : max_q;
        end else begin
            merged = smp_valid ? smp_data : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q  <= '0;
            max_q      <= '0;
            have_q     <= 1'b0;
            peak_valid <= 1'b0;
            peak_value <= '0;
        end else if (!run_en) begin
            win_cnt_q  <= '0;
            max_q      <= '0;
            have_q     <= 1'b0;
            peak_valid <= 1'b0;
        end else begin
            peak_valid <= win_end;
            if (win_end) begin
                win_cnt_q  <= '0;
                peak_value <= merged;
                max_q      <= '0;
                have_q     <= 1'b0;
            end else begin
                win_cnt_q <= win_cnt_q + 1'b1;
                max_q     <= merged;
                have_q    <= have_q | smp_valid;
            end
        end
    end

    p_peak_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |=> !peak_valid);

    p_no_peak_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !peak_valid);

    p_max_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && smp_valid && !win_end) |=> (max_q >= $past(smp_data)));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt_q <= WIN_LAST);
endmodule

// File: rtl/lpg_uv_timer.sv
module lpg_uv_timer #(
    parameter int DELAY_CYC = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic expired
);
    localparam int DCW = $clog2(DELAY_CYC);
    localparam logic [DCW-1:0] DLY_LAST = DCW'(DELAY_CYC - 1);

    logic [DCW-1:0] cnt_q;

    assign expired = count_en && (cnt_q == DLY_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_delay_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DLY_LAST);

    p_delay_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (cnt_q == '0));
endmodule

// File: rtl/lpg_brownout_fsm.sv
module lpg_brownout_fsm
    import lpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic peak_valid,
    input  logic peak_low,
    input  logic uv_expired,
    output logic uv_count_en,
    output logic brownout_evt,
    output logic pwm_halt,
    output logic lp_req
);
    lpg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = ST_IDLE;                       // disarm
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_WATCH;     // arm
                ST_WATCH: begin
                    if (peak_valid && peak_low) state_d = ST_LOW_WAIT;  // sag
                end
                ST_LOW_WAIT: begin
                    if (peak_valid && !peak_low) state_d = ST_WATCH;    // recover
                    else if (uv_expired)         state_d = ST_TRIPPED;  // trip
                end
                ST_TRIPPED:  state_d = ST_TRIPPED;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brownout_evt <= 1'b0;
        else        brownout_evt <= (state_d == ST_TRIPPED) && (state_q != ST_TRIPPED);
    end

    always_comb begin
        uv_count_en = (state_q == ST_LOW_WAIT);
        lp_req      = (state_q == ST_TRIPPED);
        pwm_halt    = (state_q == ST_IDLE) || (state_q == ST_TRIPPED);
    end

    p_event_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_evt |=> !brownout_evt);

    p_tripped_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIPPED && run_en) |=> (state_q == ST_TRIPPED));

    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_IDLE));

    p_event_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brownout_evt) |-> ($past(state_q) == ST_LOW_WAIT));

    p_equal_healthy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH && run_en && peak_valid && !peak_low) |=> (state_q == ST_WATCH));

    p_run_no_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH || state_q == ST_LOW_WAIT) |-> !pwm_halt);
endmodule

// File: rtl/line_peak_guard.sv
module line_peak_guard #(
    parameter int SAMPLE_W   = 10,
    parameter int WINDOW_CYC = 2_200_000,
    parameter int DELAY_CYC  = 4_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] acoff_lvl,
    output logic                peak_valid,
    output logic [SAMPLE_W-1:0] peak_value,
    output logic                brownout_evt,
    output logic                pwm_halt,
    output logic                lp_req
);
    logic peak_low;
    logic uv_count_en;
    logic uv_expired;

    // equality with the level counts as healthy
    assign peak_low = peak_value < acoff_lvl;

    lpg_window_peak #(
        .SAMPLE_W  (SAMPLE_W),
        .WINDOW_CYC(WINDOW_CYC)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .peak_valid(peak_valid),
        .peak_value(peak_value)
    );

    lpg_uv_timer #(
        .DELAY_CYC(DELAY_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(uv_count_en),
        .expired (uv_expired)
    );

    lpg_brownout_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .peak_valid  (peak_valid),
        .peak_low    (peak_low),
        .uv_expired  (uv_expired),
        .uv_count_en (uv_count_en),
        .brownout_evt(brownout_evt),
        .pwm_halt    (pwm_halt),
        .lp_req      (lp_req)
    );

    p_low_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_evt |-> lp_req);

    p_halt_on_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |-> pwm_halt);
endmodule

// File: tb/line_peak_guard_bench.sv
`timescale 1ns/1ps
module line_peak_guard_bench;
    localparam int SW = 10;
    localparam int W  = 40;
    localparam int D  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [SW-1:0] acoff_lvl = 10'd300;
    logic          peak_valid;
    logic [SW-1:0] peak_value;
    logic          brownout_evt;
    logic          pwm_halt;
    logic          lp_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pk_count = 0;
    int pk_cyc = 0;
    int last_pk = 0;
    int bo_count = 0;
    int bo_cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_peak_guard #(
        .SAMPLE_W(SW), .WINDOW_CYC(W), .DELAY_CYC(D)
    ) u_line_peak_guard (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .smp_valid(smp_valid), .smp_data(smp_data), .acoff_lvl(acoff_lvl),
        .peak_valid(peak_valid), .peak_value(peak_value),
        .brownout_evt(brownout_evt), .pwm_halt(pwm_halt), .lp_req(lp_req)
    );

    // port monitor: records edge index of each event
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        if (peak_valid) begin
            pk_count = pk_count + 1;
            pk_cyc   = cyc;
            last_pk  = int'(peak_value);
        end
        if (brownout_evt) begin
            bo_count = bo_count + 1;
            bo_cyc   = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller stands at a negedge; returns at the negedge after the window end
    task automatic feed_window(input int hi, input int pos, input bit sparse);
        for (int k = 0; k < W; k++) begin
            smp_valid = (hi >= 0) && ((k == pos) || !sparse || (k % 3 == 0));
            if (k == pos)  smp_data = SW'(hi);
            else if (hi > 8) smp_data = SW'(hi - 1 - (k % 7));
            else           smp_data = '0;
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic window_expect(input int hi, input int pos, input bit sparse, input string req);
        int n0;
        n0 = pk_count;
        feed_window(hi, pos, sparse);
        check(pk_count == n0 + 1, {req, " one peak per window"}, pk_count - n0, 1);
        check(last_pk == ((hi < 0) ? 0 : hi), {req, " peak value"}, last_pk, (hi < 0) ? 0 : hi);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(peak_valid == 1'b0, "R1 peak_valid", int'(peak_valid), 0);
        check(brownout_evt == 1'b0, "R1 brownout_evt", int'(brownout_evt), 0);
        check(lp_req == 1'b0, "R1 lp_req", int'(lp_req), 0);
        check(pwm_halt == 1'b1, "R1 pwm_halt", int'(pwm_halt), 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_windows;
        int c_en, p1;
        c_en = cyc;
        run_en = 1'b1;
        window_expect(700, 20, 1'b0, "R3 mid peak");
        check(pk_cyc == c_en + W, "R2 first peak edge", pk_cyc, c_en + W);
        check(pwm_halt == 1'b0, "R10 halt low in WATCH", int'(pwm_halt), 0);
        p1 = pk_cyc;
        window_expect(600, 0, 1'b0, "R4 lower after higher");
        check(pk_cyc - p1 == W, "R2 period", pk_cyc - p1, W);
        window_expect(650, W - 1, 1'b1, "R3 last-edge sample");
        window_expect(-1, -1, 1'b0, "R3 empty window");
        window_expect(500, 7, 1'b1, "R7 recovery after empty");
        check(bo_count == 0, "R7 no trip after recovery", bo_count, 0);
    endtask

    task automatic t_equal;
        for (int i = 0; i < 4; i++) window_expect(300, 11, 1'b0, "R5 equal level");
        check(bo_count == 0, "R5 equal never trips", bo_count, 0);
        check(pwm_halt == 1'b0, "R10 halt low", int'(pwm_halt), 0);
    endtask

    task automatic t_brownout;
        int t0, n0;
        n0 = bo_count;
        window_expect(200, 5, 1'b0, "R6 low peak");
        t0 = pk_cyc;
        check(pwm_halt == 1'b0, "R10 halt low in LOW_WAIT", int'(pwm_halt), 0);
        for (int i = 0; i < 3; i++) feed_window(200, 5, 1'b0);
        check(bo_count == n0 + 1, "R6 single event", bo_count - n0, 1);
        check(bo_cyc == t0 + D + 1, "R6 event edge", bo_cyc, t0 + D + 1);
        check(lp_req == 1'b1, "R8 lp_req held", int'(lp_req), 1);
        check(pwm_halt == 1'b1, "R8 pwm_halt held", int'(pwm_halt), 1);
        for (int i = 0; i < 3; i++) feed_window(200, 5, 1'b0);
        feed_window(800, 3, 1'b0);
        check(bo_count == n0 + 1, "R8 no repeat event", bo_count - n0, 1);
        check(lp_req == 1'b1, "R8 lp_req still held", int'(lp_req), 1);
    endtask

    task automatic t_disable;
        int n0;
        run_en = 1'b0;
        @(negedge clk);
        check(lp_req == 1'b0, "R9 lp_req cleared", int'(lp_req), 0);
        check(pwm_halt == 1'b1, "R9 pwm_halt in IDLE", int'(pwm_halt), 1);
        n0 = pk_count;
        smp_valid = 1'b1;
        smp_data  = 10'd900;
        repeat (2 * W) @(negedge clk);
        smp_valid = 1'b0;
        check(pk_count == n0, "R9 no peak while disabled", pk_count - n0, 0);
    endtask

    task automatic t_restart;
        int c_en, t1, n0;
        c_en = cyc;
        run_en = 1'b1;
        window_expect(650, 30, 1'b0, "R9 restart window");
        check(pk_cyc == c_en + W, "R9 window restarts", pk_cyc, c_en + W);
        n0 = bo_count;
        window_expect(100, 2, 1'b0, "R7 first sag");
        window_expect(500, 2, 1'b0, "R7 recover");
        window_expect(100, 2, 1'b0, "R7 second sag");
        t1 = pk_cyc;
        for (int i = 0; i < 3; i++) feed_window(100, 2, 1'b0);
        check(bo_count == n0 + 1, "R7 one event", bo_count - n0, 1);
        check(bo_cyc == t1 + D + 1, "R7 full delay restarted", bo_cyc, t1 + D + 1);
    endtask

    initial begin
        t_reset();
        t_windows();
        t_equal();
        t_brownout();
        t_disable();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule